// File: doc/BRIEF.md
# Geiger-Mode Photodiode Quench and Recharge Sequencer

This block is the digital sequencer for one pixel of a single-photon avalanche diode array. Its input is the comparator output after synchronization; that output goes high when the diode node crosses the detection threshold. While the pixel is armed, a rising comparator edge sets a quench latch. The latch drives the inhibit switch, which clamps the diode node to the supply. The block also starts a fixed-width hit pulse, which feeds the array-wide wired OR.

A programmable hold interval clears the latch. A falling-edge detector on the latch output then starts the recharge switch pulse, whose width is the high edge setting. A settle interval follows, whose length is the low edge setting. During settle the comparator is still blanked. The pixel re-arms only after it samples the comparator low. All intervals count clock cycles. Each one takes its setting when it starts, and a zero setting counts as one cycle.

Top module: `spad_quench_seq`

## Requirements
- R1: While rst_n is low at a clock edge, inhibit_o, recharge_o and hit_o are all low after that edge, and the block is left armed.
- R2: In the armed state, if comp_sync_i is sampled high at an edge and was sampled low at the previous edge, inhibit_o and hit_o are both high after that same edge.
- R3: inhibit_o stays high for exactly max(hold_cfg_i,1) cycles.
- R4: After inhibit_o falls, both switch enables stay low for exactly one cycle. recharge_o is then high for exactly max(edge_hi_cfg_i,1) cycles. inhibit_o and recharge_o are never high together.
- R5: After recharge_o falls, the block stays unarmed for max(edge_lo_cfg_i,1) cycles, and comparator edges in that interval start no detection.
- R6: After settle, the block re-arms at the first edge where comp_sync_i is sampled low. A comparator held high across the whole sequence produces no second detection. A fresh low-to-high transition is needed.
- R7: Every accepted detection produces exactly one hit_o pulse of HIT_W cycles, starting with inhibit_o.
- R8: Comparator edges during hold, the dead cycle or recharge are ignored: they do not extend inhibit_o and do not start a hit pulse.
- R9: A setting of 0 for hold, edge high or edge low behaves as 1 cycle; the largest value (63 with 6-bit settings) gives that many cycles.
- R10: Each interval uses the setting that is present when the interval starts. A setting changed during an interval does not alter that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comp_sync_i | input | 1 | Synchronized threshold comparator output |
| hold_cfg_i | input | CFG_W | Hold interval in cycles |
| edge_hi_cfg_i | input | CFG_W | Recharge pulse width in cycles |
| edge_lo_cfg_i | input | CFG_W | Post-recharge settle interval in cycles |
| inhibit_o | output | 1 | Quench (inhibit) switch enable |
| recharge_o | output | 1 | Recharge (reset) switch enable |
| hit_o | output | 1 | Monostable hit pulse to the array OR |

## Verification
The embedded properties are checked on every cycle. They cover the mutual exclusion of the two switch enables and the dead cycle between them. They also check that a hit pulse can start only when the latch sets, that no hit starts outside the armed phase, and that reset clears the outputs. The exact interval lengths, the zero-as-one rule, and the capture of settings at interval start can be shown only by the bench's scenarios. The same holds for comparator edges that fall in the settle window or stay high across re-arm. For these the scenarios measure the run lengths of each output against the values computed from the settings.

// File: rtl/spadq_pkg.sv
package spadq_pkg;

   typedef enum logic [2:0] {
      PH_ARMED  = 3'd0,
      PH_HOLD   = 3'd1,
      PH_GAP    = 3'd2,
      PH_RECHG  = 3'd3,
      PH_SETTLE = 3'd4,
      PH_REARM  = 3'd5
   } phase_e;

endpackage

// File: rtl/spadq_edge_det.sv
module spadq_edge_det #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic pulse_o
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_i;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse_o = sig_i & ~prev_q;
      end else begin : g_fall
         assign pulse_o = ~sig_i & prev_q;
      end
   endgenerate

endmodule

// File: rtl/spadq_timer.sv
module spadq_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_eff;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("spadq_timer: CNT_W must be at least 1");
      end
   endgenerate

   assign load_eff = (load_val_i == '0) ? CNT_W'(1) : load_val_i;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_eff;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expire_o = (cnt_q == CNT_W'(1));

   p_load_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q != '0));

   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/spadq_monoflop.sv
module spadq_monoflop #(
   parameter int HIT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic out_o
);

   localparam int HW = $clog2(HIT_W + 1);

   logic [HW-1:0] cnt_q;

   generate
      if (HIT_W < 1) begin : g_bad_hit
         $error("spadq_monoflop: HIT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (fire_i)       cnt_q <= HW'(HIT_W);
      else if (cnt_q != '0)  cnt_q <= cnt_q - HW'(1);
   end

   assign out_o = (cnt_q != '0);

   p_fire_sets_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> out_o);

endmodule

// File: rtl/spad_quench_seq.sv
module spad_quench_seq
   import spadq_pkg::*;
#(
   parameter int CFG_W = 6,
   parameter int HIT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             comp_sync_i,
   input  logic [CFG_W-1:0] hold_cfg_i,
   input  logic [CFG_W-1:0] edge_hi_cfg_i,
   input  logic [CFG_W-1:0] edge_lo_cfg_i,
   output logic             inhibit_o,
   output logic             recharge_o,
   output logic             hit_o
);

   generate
      if (CFG_W < 1 || CFG_W > 16) begin : g_bad_cfg
         $error("spad_quench_seq: CFG_W out of range 1..16");
      end
      if (HIT_W < 1) begin : g_bad_hitw
         $error("spad_quench_seq: HIT_W must be at least 1");
      end
   endgenerate

   phase_e           phase_q, phase_d;
   logic             latch_q;
   logic             comp_rise;
   logic             latch_fall;
   logic             accept;
   logic             t_load;
   logic [CFG_W-1:0] t_val;
   logic             t_expire;

   spadq_edge_det #(.RISING(1'b1)) u_comp_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sig_i   (comp_sync_i),
      .pulse_o (comp_rise)
   );

   spadq_edge_det #(.RISING(1'b0)) u_latch_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sig_i   (latch_q),
      .pulse_o (latch_fall)
   );

   spadq_timer #(.CNT_W(CFG_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (t_load),
      .load_val_i (t_val),
      .expire_o   (t_expire)
   );

   spadq_monoflop #(.HIT_W(HIT_W)) u_hit (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (accept),
      .out_o  (hit_o)
   );

   assign accept = (phase_q == PH_ARMED) && comp_rise;

   // Phase sequencing; the shared timer is reloaded on each timed entry
   always_comb begin
      phase_d = phase_q;
      t_load  = 1'b0;
      t_val   = hold_cfg_i;
      unique case (phase_q)
         PH_ARMED: begin
            if (accept) begin
               phase_d = PH_HOLD;
               t_load  = 1'b1;
               t_val   = hold_cfg_i;
            end
         end
         PH_HOLD: begin
            if (t_expire) phase_d = PH_GAP;
         end
         PH_GAP: begin
            if (latch_fall) begin
               phase_d = PH_RECHG;
               t_load  = 1'b1;
               t_val   = edge_hi_cfg_i;
            end
         end
         PH_RECHG: begin
            if (t_expire) begin
               phase_d = PH_SETTLE;
               t_load  = 1'b1;
               t_val   = edge_lo_cfg_i;
            end
         end
         PH_SETTLE: begin
            if (t_expire) phase_d = PH_REARM;
         end
         PH_REARM: begin
            if (!comp_sync_i) phase_d = PH_ARMED;
         end
         default: phase_d = PH_ARMED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_ARMED;
      else        phase_q <= phase_d;
   end

   // Quench latch: set by an accepted crossing, cleared by hold expiry
   always_ff @(posedge clk) begin
      if (!rst_n)                                latch_q <= 1'b0;
      else if (accept)                           latch_q <= 1'b1;
      else if (phase_q == PH_HOLD && t_expire)   latch_q <= 1'b0;
   end

   assign inhibit_o  = latch_q;
   assign recharge_o = (phase_q == PH_RECHG);

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (!inhibit_o && !recharge_o && !hit_o));

   p_switch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(inhibit_o && recharge_o));

   p_dead_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inhibit_o) |-> (!recharge_o ##1 recharge_o));

   p_hit_with_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit_o) |-> $rose(inhibit_o));

   p_no_hit_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_ARMED) |=> !$rose(hit_o));

   p_high_blocks_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_REARM && comp_sync_i) |=> (phase_q == PH_REARM));

   p_settle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SETTLE) |-> (!inhibit_o && !recharge_o));

endmodule

// File: tb/tb_spad_quench_seq.sv
module tb_spad_quench_seq;

   localparam int CLK_PERIOD = 10;
   localparam int CFG_W      = 6;
   localparam int HIT_W      = 4;
   localparam int WD_CYCLES  = 100000;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             comp;
   logic [CFG_W-1:0] hold_cfg, ehi_cfg, elo_cfg;
   logic             inhibit_o, recharge_o, hit_o;

   spad_quench_seq #(.CFG_W(CFG_W), .HIT_W(HIT_W)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .comp_sync_i   (comp),
      .hold_cfg_i    (hold_cfg),
      .edge_hi_cfg_i (ehi_cfg),
      .edge_lo_cfg_i (elo_cfg),
      .inhibit_o     (inhibit_o),
      .recharge_o    (recharge_o),
      .hit_o         (hit_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct { int h; int eh; } exp_t;
   exp_t exp_q[$];

   int n_checks = 0;
   int n_fail   = 0;
   int n_push   = 0;
   int hit_runs = 0;
   bit done     = 0;

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   // Driver: one accepted detection per call; comp follows pat bit i at negedge i
   task automatic run_pat(input int h, input int eh, input int el,
                          input logic [31:0] pat, input int len, input int alt_h);
      exp_t e;
      @(negedge clk);
      check(!inhibit_o && !recharge_o, "R6 idle before detection", int'(inhibit_o), 0);
      hold_cfg = CFG_W'(h);
      ehi_cfg  = CFG_W'(eh);
      elo_cfg  = CFG_W'(el);
      comp     = pat[0];
      e.h  = eff(h);
      e.eh = eff(eh);
      exp_q.push_back(e);
      n_push++;
      for (int i = 1; i < len; i++) begin
         @(negedge clk);
         if (i == 1) begin
            check(inhibit_o == 1'b1, "R2 inhibit on first edge", int'(inhibit_o), 1);
            check(hit_o == 1'b1, "R2 hit on first edge", int'(hit_o), 1);
            if (alt_h >= 0) hold_cfg = CFG_W'(alt_h);   // R10 mid-hold change
         end
         comp = pat[i];
      end
      @(negedge clk);
      comp = 1'b0;
      repeat (eff(h) + eff(eh) + eff(el) + 6) @(negedge clk);
   endtask

   // Monitor: measures switch run lengths and pops the scoreboard
   initial begin
      int inh, gap, rch;
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n && inhibit_o) begin
            inh = 0;
            while (inhibit_o) begin inh++; @(negedge clk); end
            gap = 0;
            while (!recharge_o && gap < 200) begin gap++; @(negedge clk); end
            rch = 0;
            while (recharge_o) begin rch++; @(negedge clk); end
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected detection", 1, 0);
            end else begin
               e = exp_q.pop_front();
               check(inh == e.h, "R3 inhibit length", inh, e.h);
               check(gap == 1, "R4 dead cycle", gap, 1);
               check(rch == e.eh, "R4 recharge length", rch, e.eh);
            end
         end
      end
   end

   // Monitor: hit pulse widths
   initial begin
      int len;
      forever begin
         @(negedge clk);
         if (rst_n && hit_o) begin
            len = 0;
            while (hit_o) begin len++; @(negedge clk); end
            hit_runs++;
            check(len == HIT_W, "R7 hit width", len, HIT_W);
         end
      end
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      rst_n    = 1'b0;
      comp     = 1'b1;
      hold_cfg = '0;
      ehi_cfg  = '0;
      elo_cfg  = '0;
      repeat (3) @(negedge clk);
      // R1: reset holds all outputs low even with comparator high
      check(!inhibit_o && !recharge_o && !hit_o, "R1 reset outputs",
            int'({inhibit_o, recharge_o, hit_o}), 0);
      comp = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!inhibit_o && !recharge_o && !hit_o, "R1 after release",
            int'({inhibit_o, recharge_o, hit_o}), 0);

      // R2 R3 R4: plain detections with distinct settings
      run_pat(3, 2, 2, 32'h1, 2, -1);
      run_pat(10, 5, 1, 32'h3, 3, -1);
      // R9: zero settings act as one, max settings act as 63
      run_pat(0, 0, 0, 32'h1, 2, -1);
      run_pat(63, 63, 63, 32'h1, 2, -1);
      // R8: comparator toggling during hold, dead cycle and recharge
      run_pat(5, 3, 2, 32'hB5, 8, -1);
      // R5: new rising edge inside the settle window
      run_pat(2, 2, 6, 32'h181, 9, -1);
      // R6: comparator held high through the whole sequence
      run_pat(1, 1, 1, 32'hFFFFF, 20, -1);
      // R6: immediate fresh edge after re-arm
      run_pat(2, 1, 1, 32'h1, 2, -1);
      // R10: hold setting changed during hold
      run_pat(4, 2, 2, 32'h1, 3, 20);

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R3 all detections observed", exp_q.size(), 0);
      check(hit_runs == n_push, "R7 one hit per detection", hit_runs, n_push);
      finish_run();
   end

endmodule